// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Emulator

This block lets a design that expects an asynchronous 16-bit static RAM talk to on-chip storage. The RAM side provides an active-low select, write strobe, output enable and one active-low enable per byte lane. A fast system clock samples these pins, the address and the input data through a two-stage synchronizer. The sampled controls drive a mode state machine and a write tracker. Read data leaves on a separate output bus. A per-lane drive flag stands in for the tri-state pads, so a flag of 0 means that lane floats. A standby flag shows when the select is inactive.

A write to a lane lasts while select, write strobe and that lane's enable are all low. The lane's data is committed when the first of these strobes returns high. The word address is captured when the write starts. If the address moves while the write is still active, a sticky protocol-error flag is raised. The default build holds 1024 words (`ADDR_W`=10). Setting `ADDR_W`=15 gives the full 32K-word array.

All pin-to-output behaviour has three clock cycles of latency: two synchronizer stages and one output register.

The state machine has seven states:
- `ST_STANDBY`: select is high.
- `ST_DESEL`: selected, but both lane enables are high.
- `ST_OUTOFF`: selected and no write, but output enable is high.
- `ST_READ`: selected with output enable low.
- `ST_WRITE`: a write that was entered from a selected state.
- `ST_WRITE_Z`: a write whose strobe was already low when select fell.
- `ST_MUTE`: a held-quiet selection that follows `ST_WRITE_Z`.

The transitions are:
- Select high goes to `ST_STANDBY` from any state.
- An active write goes to `ST_WRITE_Z` from `ST_STANDBY`, `ST_WRITE_Z` or `ST_MUTE`, and to `ST_WRITE` from any other state.
- With no write, `ST_WRITE_Z` and `ST_MUTE` go to `ST_MUTE`.
- With no write, every other state goes to `ST_DESEL`, then `ST_OUTOFF`, then `ST_READ`, by that priority, according to the lane enables and output enable.

Top module: `bytelane_sram_model`

## Requirements
- R1: After reset, `standby` is 1, `dout_en` is 00, `proto_err` is 0 and `dout` is 0.
- R2: While `cs_n` is high, `standby` is 1 and both lanes are undriven.
- R3: A read happens when `cs_n`=0, `we_n`=1, `oe_n`=0 and at least one lane enable is low. Bit 0 of `dout_en` is the lower lane (`dout[7:0]`, enabled by `lo_en_n`). Bit 1 is the upper lane (`dout[15:8]`, enabled by `hi_en_n`). Only a lane whose enable is low drives, and it drives the stored byte at `addr`.
- R4: With `cs_n`=0, `we_n`=1 and `oe_n`=1, both lanes are undriven.
- R5: With both lane enables high, nothing is written and both lanes are undriven, even with `we_n` low.
- R6: A write to both lanes stores `din` at the address, and a later read returns it.
- R7: A write stores only the lanes whose enable is low. The other lane keeps its old content.
- R8: Each lane commits the data sampled just before the first of its strobes rose. When one lane's enable rises early, that lane keeps its data even if `din` then changes while the other lane is still writing.
- R9: The address is held from the start of a write. An address change during the write sets `proto_err` and does not redirect the data. `proto_err` clears when the next write starts.
- R10: While a write is active, both lanes are undriven regardless of `oe_n`.
- R11: If `we_n` is already low when `cs_n` falls, both lanes stay undriven until `cs_n` returns high, even after `we_n` rises with `oe_n` low.
- R12: Strobes that rise in the same sample give one commit of the sampled data.
- R13: When a write ends into a read of the same address, the first driven output cycle already shows the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| lo_en_n | input | 1 | Active-low lower-lane enable |
| hi_en_n | input | 1 | Active-low upper-lane enable |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Write data |
| dout | output | 16 | Read data |
| dout_en | output | 2 | Per-lane drive flag (bit 0 lower, bit 1 upper) |
| standby | output | 1 | High while the select is inactive |
| proto_err | output | 1 | Sticky flag for an address change during a write |

## Verification
Two functions can land on the same clock edge: the commit of a finished write, and the first read load of the same word. The bench provokes this by raising `we_n` while `cs_n` and `oe_n` stay low. It samples exactly three edges later, in the first cycle the lanes drive, and expects the new word rather than the stale one. A second overlap comes from ending one lane's write while the other lane keeps writing and the data changes. Each lane is then judged by reading it back after the write.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

    localparam int LANES = 2;

    typedef enum logic [2:0] {
        ST_STANDBY,
        ST_DESEL,
        ST_OUTOFF,
        ST_READ,
        ST_WRITE,
        ST_WRITE_Z,
        ST_MUTE
    } emu_state_t;

endpackage

// File: rtl/sample_pipe.sv
module sample_pipe #(
    parameter int           W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    // Two-flop synchronizer; both stages reset to the idle pin pattern.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/write_track.sv
module write_track
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    we_n,
    input  logic [LANES-1:0]        be_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] din,
    output logic                    wr_now,
    output logic [LANES-1:0]        commit,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [LANES*LANE_W-1:0] wr_data,
    output logic                    proto_err
);

    localparam int DATA_W = LANES * LANE_W;

    logic [LANES-1:0]  lane_now;
    logic [LANES-1:0]  lane_was;
    logic [DATA_W-1:0] din_was;
    logic [ADDR_W-1:0] held_addr;
    logic              wr_was;
    logic              wr_start;

    // A lane is writing while select, strobe and its own enable are low.
    assign lane_now = {LANES{~cs_n & ~we_n}} & ~be_n;
    assign wr_now   = |lane_now;
    assign wr_was   = |lane_was;
    assign wr_start = wr_now & ~wr_was;

    // First trailing strobe ends the lane; simultaneous rises give one edge.
    assign commit  = lane_was & ~lane_now;
    assign wr_addr = held_addr;
    assign wr_data = din_was;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_was <= '0;
            din_was  <= '0;
        end else begin
            lane_was <= lane_now;
            din_was  <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_addr <= '0;
            proto_err <= 1'b0;
        end else if (wr_start) begin
            held_addr <= addr;
            proto_err <= 1'b0;
        end else if (wr_now && (addr != held_addr)) begin
            proto_err <= 1'b1;
        end
    end

endmodule

// File: rtl/ctrl_fsm.sv
module ctrl_fsm
    import sram_emu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             oe_n,
    input  logic [LANES-1:0] be_n,
    input  logic             wr_now,
    output emu_state_t       st,
    output logic [LANES-1:0] lane_load,
    output logic [LANES-1:0] lane_drive,
    output logic             standby
);

    emu_state_t nxt;

    always_comb begin
        nxt = st;
        if (cs_n) begin
            nxt = ST_STANDBY;
        end else if (wr_now) begin
            unique case (st)
                ST_STANDBY, ST_WRITE_Z, ST_MUTE: nxt = ST_WRITE_Z;
                default:                         nxt = ST_WRITE;
            endcase
        end else begin
            unique case (st)
                ST_WRITE_Z, ST_MUTE: nxt = ST_MUTE;
                default: begin
                    if (&be_n)     nxt = ST_DESEL;
                    else if (oe_n) nxt = ST_OUTOFF;
                    else           nxt = ST_READ;
                end
            endcase
        end
    end

    assign lane_load = (nxt == ST_READ) ? ~be_n : '0;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_STANDBY;
        else        st <= nxt;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_drive <= '0;
            standby    <= 1'b1;
        end else begin
            lane_drive <= lane_load;
            standby    <= (nxt == ST_STANDBY);
        end
    end

endmodule

// File: rtl/lane_store.sv
module lane_store
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        wr_lane,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic [LANES-1:0]        rd_load,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] q_r;
        logic              fwd;

        assign fwd = wr_lane[g] && (wr_addr == rd_addr);

        always_ff @(posedge clk) begin
            if (wr_lane[g]) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        // A commit and a read of the same word on one edge: pass new data through.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          q_r <= '0;
            else if (rd_load[g]) q_r <= fwd ? wr_data[g*LANE_W +: LANE_W] : mem[rd_addr];
        end

        assign rd_data[g*LANE_W +: LANE_W] = q_r;
    end

endmodule

// File: rtl/bytelane_sram_model.sv
module bytelane_sram_model
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    we_n,
    input  logic                    oe_n,
    input  logic                    lo_en_n,
    input  logic                    hi_en_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic [LANES-1:0]        dout_en,
    output logic                    standby,
    output logic                    proto_err
);

    localparam int DATA_W = LANES * LANE_W;
    localparam int PIN_W  = 3 + LANES + ADDR_W + DATA_W;
    localparam int P_CS   = PIN_W - 1;
    localparam int P_WE   = PIN_W - 2;
    localparam int P_OE   = PIN_W - 3;
    localparam int P_BE   = ADDR_W + DATA_W;
    localparam logic [PIN_W-1:0] PIN_IDLE = {{(3 + LANES){1'b1}}, {(ADDR_W + DATA_W){1'b0}}};

    logic [PIN_W-1:0]  pin_raw;
    logic [PIN_W-1:0]  pin_now;
    logic              cs_now, we_now, oe_now;
    logic [LANES-1:0]  be_now;
    logic [ADDR_W-1:0] addr_now;
    logic [DATA_W-1:0] din_now;

    logic              wr_now;
    logic [LANES-1:0]  commit;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [LANES-1:0]  lane_load;
    emu_state_t        st;

    assign pin_raw  = {cs_n, we_n, oe_n, hi_en_n, lo_en_n, addr, din};
    assign cs_now   = pin_now[P_CS];
    assign we_now   = pin_now[P_WE];
    assign oe_now   = pin_now[P_OE];
    assign be_now   = pin_now[P_BE +: LANES];
    assign addr_now = pin_now[DATA_W +: ADDR_W];
    assign din_now  = pin_now[0 +: DATA_W];

    sample_pipe #(.W(PIN_W), .RST_VAL(PIN_IDLE)) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_raw),
        .q     (pin_now)
    );

    write_track #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_now),
        .we_n      (we_now),
        .be_n      (be_now),
        .addr      (addr_now),
        .din       (din_now),
        .wr_now    (wr_now),
        .commit    (commit),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .proto_err (proto_err)
    );

    ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_now),
        .oe_n       (oe_now),
        .be_n       (be_now),
        .wr_now     (wr_now),
        .st         (st),
        .lane_load  (lane_load),
        .lane_drive (dout_en),
        .standby    (standby)
    );

    lane_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lane (commit),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (addr_now),
        .rd_load (lane_load),
        .rd_data (dout)
    );

endmodule

// File: rtl/sram_emu_chk.sv
module sram_emu_chk
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input emu_state_t        st,
    input logic              wr_now,
    input logic [LANES-1:0]  be_now,
    input logic [LANES-1:0]  dout_en,
    input logic              standby,
    input logic [ADDR_W-1:0] wr_addr
);

    p_standby_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> dout_en == '0);

    p_lane_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en[0] |-> $past(!be_now[0]));

    p_desel_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (be_now == '1) |=> dout_en == '0);

    p_write_mutes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_now |=> dout_en == '0);

    p_addr_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && $past(wr_now)) |=> wr_addr == $past(wr_addr));

    p_mute_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MUTE) |-> dout_en == '0);

endmodule

bind bytelane_sram_model sram_emu_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .st      (st),
    .wr_now  (wr_now),
    .be_now  (be_now),
    .dout_en (dout_en),
    .standby (standby),
    .wr_addr (wr_addr)
);

// File: tb/tb_bytelane_sram_model.sv
module tb_bytelane_sram_model;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lo_en_n = 1'b1, hi_en_n = 1'b1;
    logic [9:0]  addr = '0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic [1:0]  dout_en;
    logic        standby, proto_err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        logic [1:0]  en;
        logic [15:0] val;
        logic [15:0] msk;
        logic        sb;
        logic        er;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;

    bytelane_sram_model dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .lo_en_n(lo_en_n), .hi_en_n(hi_en_n), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en), .standby(standby), .proto_err(proto_err)
    );

    task automatic drive(input logic c, input logic w, input logic o, input logic h,
                         input logic l, input logic [9:0] a, input logic [15:0] d);
        @(negedge clk);
        cs_n = c; we_n = w; oe_n = o; hi_en_n = h; lo_en_n = l; addr = a; din = d;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic expect_item(input string tag, input logic [1:0] en, input logic [15:0] val,
                               input logic [15:0] msk, input logic sb, input logic er);
        exp_t it;
        it.tag = tag; it.en = en; it.val = val; it.msk = msk; it.sb = sb; it.er = er;
        exp_q.push_back(it);
    endtask

    // Monitor: compare one expected item per falling edge.
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            exp_t it;
            it = exp_q.pop_front();
            total++;
            if (dout_en !== it.en || (dout & it.msk) !== (it.val & it.msk) ||
                standby !== it.sb || proto_err !== it.er) begin
                bad++;
                $display("FAIL %s: got en=%b dout=%h sb=%b err=%b, want en=%b dout=%h(mask %h) sb=%b err=%b",
                         it.tag, dout_en, dout, standby, proto_err,
                         it.en, it.val, it.msk, it.sb, it.er);
            end
        end
    end

    initial begin
        wait_cyc(100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hang, want completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        @(negedge clk);
        rst_n = 1'b1;
        wait_cyc(2);
        expect_item("R1 reset", 2'b00, 16'h0000, 16'hFFFF, 1'b1, 1'b0);

        // R4: selected, outputs disabled
        drive(0, 1, 1, 0, 0, 10'd5, 16'h0000); wait_cyc(4);
        expect_item("R4 output disable", 2'b00, 16'h0, 16'h0, 1'b0, 1'b0);
        // R10: write with oe low keeps lanes off
        drive(0, 0, 0, 0, 0, 10'd5, 16'h1234); wait_cyc(4);
        expect_item("R10 write mutes", 2'b00, 16'h0, 16'h0, 1'b0, 1'b0);
        // R13: end write into read of same word, first driven cycle
        drive(0, 1, 0, 0, 0, 10'd5, 16'h1234); wait_cyc(3);
        expect_item("R13 forward", 2'b11, 16'h1234, 16'hFFFF, 1'b0, 1'b0);
        wait_cyc(2);
        expect_item("R6 both lanes", 2'b11, 16'h1234, 16'hFFFF, 1'b0, 1'b0);
        // R3: per-lane reads
        drive(0, 1, 0, 0, 1, 10'd5, 16'h0000); wait_cyc(4);
        expect_item("R3 upper only", 2'b10, 16'h1200, 16'hFF00, 1'b0, 1'b0);
        drive(0, 1, 0, 1, 0, 10'd5, 16'h0000); wait_cyc(4);
        expect_item("R3 lower only", 2'b01, 16'h0034, 16'h00FF, 1'b0, 1'b0);
        // R2: standby
        drive(1, 1, 0, 0, 0, 10'd5, 16'h0000); wait_cyc(4);
        expect_item("R2 standby", 2'b00, 16'h0, 16'h0, 1'b1, 1'b0);

        // R11: strobe low before select falls
        drive(0, 0, 0, 0, 0, 10'd6, 16'hABCD); wait_cyc(4);
        expect_item("R11 write from standby", 2'b00, 16'h0, 16'h0, 1'b0, 1'b0);
        drive(0, 1, 0, 0, 0, 10'd6, 16'hABCD); wait_cyc(6);
        expect_item("R11 stays quiet", 2'b00, 16'h0, 16'h0, 1'b0, 1'b0);
        drive(1, 1, 0, 0, 0, 10'd6, 16'h0000); wait_cyc(4);
        drive(0, 1, 0, 0, 0, 10'd6, 16'h0000); wait_cyc(4);
        expect_item("R11 data stored", 2'b11, 16'hABCD, 16'hFFFF, 1'b0, 1'b0);

        // R7: lower-only write
        drive(0, 0, 0, 1, 0, 10'd6, 16'h5566); wait_cyc(4);
        drive(0, 1, 0, 0, 0, 10'd6, 16'h0000); wait_cyc(4);
        expect_item("R7 lane merge", 2'b11, 16'hAB66, 16'hFFFF, 1'b0, 1'b0);

        // R8: lower enable rises first, data changes, then strobe rises
        drive(0, 1, 1, 0, 0, 10'd7, 16'h0000); wait_cyc(4);
        drive(0, 0, 1, 0, 0, 10'd7, 16'h1111); wait_cyc(4);
        drive(0, 0, 1, 0, 1, 10'd7, 16'h1111); wait_cyc(4);
        drive(0, 0, 1, 0, 1, 10'd7, 16'h2222); wait_cyc(4);
        drive(0, 1, 1, 0, 1, 10'd7, 16'h2222); wait_cyc(4);
        drive(0, 1, 0, 0, 0, 10'd7, 16'h0000); wait_cyc(4);
        expect_item("R8 first trailing edge", 2'b11, 16'h2211, 16'hFFFF, 1'b0, 1'b0);

        // R12: select and strobe rise in one sample
        drive(0, 1, 1, 0, 0, 10'd8, 16'h0000); wait_cyc(4);
        drive(0, 0, 1, 0, 0, 10'd8, 16'h3C3C); wait_cyc(4);
        drive(1, 1, 1, 0, 0, 10'd8, 16'h3C3C); wait_cyc(4);
        drive(0, 1, 0, 0, 0, 10'd8, 16'h0000); wait_cyc(4);
        expect_item("R12 joint rise", 2'b11, 16'h3C3C, 16'hFFFF, 1'b0, 1'b0);

        // R5: both enables high blocks the write
        drive(0, 0, 0, 1, 1, 10'd8, 16'hFFFF); wait_cyc(4);
        expect_item("R5 deselected", 2'b00, 16'h0, 16'h0, 1'b0, 1'b0);
        drive(0, 1, 0, 0, 0, 10'd8, 16'h0000); wait_cyc(4);
        expect_item("R5 no write", 2'b11, 16'h3C3C, 16'hFFFF, 1'b0, 1'b0);

        // R9: address moves during a write
        drive(0, 1, 1, 0, 0, 10'd9, 16'h0000); wait_cyc(4);
        drive(0, 0, 1, 0, 0, 10'd9, 16'h4444); wait_cyc(4);
        expect_item("R9 clean write", 2'b00, 16'h0, 16'h0, 1'b0, 1'b0);
        drive(0, 0, 1, 0, 0, 10'd10, 16'h4444); wait_cyc(4);
        expect_item("R9 error raised", 2'b00, 16'h0, 16'h0, 1'b0, 1'b1);
        drive(0, 1, 1, 0, 0, 10'd10, 16'h4444); wait_cyc(4);
        drive(0, 1, 0, 0, 0, 10'd9, 16'h0000); wait_cyc(4);
        expect_item("R9 held address", 2'b11, 16'h4444, 16'hFFFF, 1'b0, 1'b1);
        drive(0, 0, 1, 0, 0, 10'd11, 16'h0000); wait_cyc(4);
        expect_item("R9 error cleared", 2'b00, 16'h0, 16'h0, 1'b0, 1'b0);
        drive(0, 1, 1, 0, 0, 10'd11, 16'h0000); wait_cyc(4);
        drive(1, 1, 1, 1, 1, 10'd0, 16'h0000); wait_cyc(4);
        expect_item("R2 final standby", 2'b00, 16'h0, 16'h0, 1'b1, 1'b0);

        wait_cyc(3);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule